// File: doc/BRIEF.md
# Multi-Mode Endian Load/Store Aligner

This block steers bytes between a core's register port and a 32-bit byte-addressed memory bus, whose lanes are numbered 0 to 3 from least to most significant bits. For each access it takes the address, the size, the direction, a signed flag and a run-time byte-order mode. On a store it produces the four lane enables and the bus write word. On a load it gathers the addressed lanes of the bus read word, restores the value's significance and extends it to the register width.

Four orderings are selectable while the block runs. The first is little-endian. The second is a big-endian variant that keeps addresses and reverses the bytes of multi-byte data. The third is a big-endian variant that leaves full words alone and mirrors the lane of byte and halfword accesses inside the word. The fourth is a mixed ordering in which a word is held as two little-endian halves, the more significant half at the lower address. Lane selection and data steering are combinational. The load result is held in a register that updates on the clock edge where read data is marked valid. A misaligned access is refused in every mode.

Top module: `endian_lane_steer`

## Requirements
- R1: Mode code 0 (little-endian): byte k of an n-byte value (n = 1, 2, 4 for size codes 0, 1, 2) uses lane addr[1:0]+k. `bus_be` has exactly those lanes set, and `bus_wdata` is zero in every lane that is not enabled.
- R2: Mode code 1 (data-reversing big-endian): a byte access matches mode 0, and byte k of a halfword or word uses lane addr[1:0]+(n-1-k).
- R3: Mode code 2 (address-mirroring big-endian): an aligned word matches mode 0, a byte access uses lane addr[1:0] XOR 3, and a halfword uses base lane addr[1:0] XOR 2 with its bytes in little-endian order.
- R4: Mode code 3 (half-swapped): byte k of a word uses lane k XOR 2, so storing 0x4A4F484E gives lanes 0..3 = 4F 4A 4E 48 (bus word 0x484E4A4F). Bytes and halfwords match mode 0.
- R5: A halfword at an odd address, a word at an address that is not a multiple of four, or size code 3 sets `align_err`, drives `bus_be` to 0, and loads zero into the result.
- R6: A byte or halfword load is zero-extended when `acc_signed` is 0. When it is 1, the load is sign-extended from bit 7 of the value's most significant byte after reordering.
- R7: `ld_data` takes the load result on the rising edge where `bus_rvalid` is 1 and `acc_write` is 0, and holds otherwise. Reset sets it to zero.
- R8: In every mode, a store followed by a load of the same size, address and mode returns the stored value truncated to the access size and then extended.
- R9: In mode 0, a word holding a value below 0x80 reads back as the same number through a byte, halfword or word load at the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| acc_write | input | 1 | 1 store, 0 load |
| acc_signed | input | 1 | Sign-extend a narrow load |
| order_mode | input | 2 | Byte-order mode code (0..3) |
| st_data | input | 32 | Store value, right-justified |
| bus_be | output | 4 | Lane enables |
| bus_wdata | output | 32 | Bus write word |
| bus_rdata | input | 32 | Bus read word |
| bus_rvalid | input | 1 | Read word valid this cycle |
| ld_data | output | 32 | Registered, aligned and extended load value |
| align_err | output | 1 | Misaligned or invalid-size access |

## Verification
The assertions take for granted that the access fields stay steady through the cycle in which `bus_rvalid` is high, and that `bus_rvalid` only marks cycles whose address, size and mode describe a load. The stimulus drives each access right after a falling edge and holds it until the next one. It raises `bus_rvalid` only for a single load cycle, with the bus word taken from a byte-array model that earlier stores updated through the enabled lanes. Random accesses are mostly aligned, with a share misaligned or of the invalid size, so the refusal path meets every mode.

// File: rtl/esteer_pkg.sv
package esteer_pkg;

    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        ORD_LE        = 2'd0,
        ORD_BE_DATA   = 2'd1,
        ORD_BE_ADDR   = 2'd2,
        ORD_HALF_SWAP = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_H   = 2'd1,
        SZ_W   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    // Map a slot (byte offset from the base lane) to the value byte it
    // carries. Every mapping is its own inverse, so loads reuse it.
    function automatic logic [1:0] slot_to_byte(order_e mode, logic [1:0] span,
                                                logic [1:0] slot);
        logic [1:0] r;
        r = slot;
        if (mode == ORD_BE_DATA)
            r = span - slot;
        else if (mode == ORD_HALF_SWAP && span == 2'd3)
            r = slot ^ 2'b10;
        return r;
    endfunction

endpackage

// File: rtl/esteer_align.sv
module esteer_align
    import esteer_pkg::*;
(
    input  logic [1:0] addr_lo,
    input  size_e      size,
    input  order_e     mode,
    output logic       err,
    output logic [1:0] base,
    output logic [1:0] span
);
    always_comb begin
        err  = 1'b0;
        base = addr_lo;
        span = 2'd0;
        case (size)
            SZ_B: begin
                span = 2'd0;
                if (mode == ORD_BE_ADDR) base = addr_lo ^ 2'b11;
            end
            SZ_H: begin
                span = 2'd1;
                err  = addr_lo[0];
                if (mode == ORD_BE_ADDR) base = addr_lo ^ 2'b10;
            end
            SZ_W: begin
                span = 2'd3;
                err  = |addr_lo;
            end
            default: begin
                span = 2'd0;
                err  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/esteer_store.sv
module esteer_store
    import esteer_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  order_e            mode,
    input  logic              err,
    input  logic [1:0]        base,
    input  logic [1:0]        span,
    input  logic [DATA_W-1:0] value,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [1:0] slot;
        logic [1:0] src;
        logic       hit;
        always_comb begin
            slot = 2'(l) - base;
            hit  = !err && (2'(l) >= base) && (slot <= span);
            src  = slot_to_byte(mode, span, slot);
            lane_en[l] = hit;
            lane_data[l*LANE_W +: LANE_W] = hit ? value[src*LANE_W +: LANE_W]
                                                : '0;
        end
    end
endmodule

// File: rtl/esteer_load.sv
module esteer_load
    import esteer_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  order_e            mode,
    input  logic              err,
    input  logic              sign_ext,
    input  logic [1:0]        base,
    input  logic [1:0]        span,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] gathered;
    logic              top_bit;

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        logic [1:0] slot;
        logic [1:0] lane;
        always_comb begin
            slot = slot_to_byte(mode, span, 2'(k));
            lane = base + slot;
            gathered[k*LANE_W +: LANE_W] = rdata[lane*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        top_bit = sign_ext && gathered[span*LANE_W + (LANE_W-1)];
        value   = '0;
        for (int k = 0; k < LANES; k++) begin
            if (2'(k) <= span)
                value[k*LANE_W +: LANE_W] = gathered[k*LANE_W +: LANE_W];
            else
                value[k*LANE_W +: LANE_W] = {LANE_W{top_bit}};
        end
        if (err) value = '0;
    end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
    import esteer_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              acc_signed,
    input  logic [1:0]        order_mode,
    input  logic [DATA_W-1:0] st_data,
    output logic [LANES-1:0]  bus_be,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid,
    output logic [DATA_W-1:0] ld_data,
    output logic              align_err
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
    } steer_state_t;

    steer_state_t state_d, state_q;

    order_e            mode;
    size_e             size;
    logic              err;
    logic [1:0]        base;
    logic [1:0]        span;
    logic [DATA_W-1:0] load_val;

    assign mode = order_e'(order_mode);
    assign size = size_e'(acc_size);

    esteer_align u_align (
        .addr_lo (acc_addr[1:0]),
        .size    (size),
        .mode    (mode),
        .err     (err),
        .base    (base),
        .span    (span)
    );

    esteer_store #(.LANE_W(LANE_W)) u_store (
        .mode      (mode),
        .err       (err),
        .base      (base),
        .span      (span),
        .value     (st_data),
        .lane_en   (bus_be),
        .lane_data (bus_wdata)
    );

    esteer_load #(.LANE_W(LANE_W)) u_load (
        .mode     (mode),
        .err      (err),
        .sign_ext (acc_signed),
        .base     (base),
        .span     (span),
        .rdata    (bus_rdata),
        .value    (load_val)
    );

    always_comb begin
        state_d = state_q;
        if (bus_rvalid && !acc_write) state_d.result = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ld_data   = state_q.result;
    assign align_err = err;
endmodule

// File: rtl/esteer_checker.sv
module esteer_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned DATA_W = 4 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic              acc_write,
    input logic [1:0]        order_mode,
    input logic [3:0]        bus_be,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] ld_data,
    input logic              align_err
);
    a_r5_refused_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> bus_be == 4'b0000);

    a_r5_refused_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && bus_rvalid && !acc_write) |=> ld_data == '0);

    a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'd0) |-> $countones(bus_be) == 1);

    a_r1_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'd1 && !align_err) |-> $countones(bus_be) == 2);

    a_r3_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_size == 2'd2 && !align_err) |-> bus_be == 4'b1111);

    a_r3_byte_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        (order_mode == 2'd2 && acc_size == 2'd0)
            |-> bus_be[~acc_addr[1:0]] == 1'b1);

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |=> $stable(ld_data));

    a_r7_hold_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && acc_write) |=> $stable(ld_data));
endmodule

bind endian_lane_steer esteer_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_endian_lane_steer.sv
module tb_endian_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic        acc_signed = 1'b0;
    logic [1:0]  order_mode = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_rvalid = 1'b0;
    logic [31:0] ld_data;
    logic        align_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mem [4];

    always #2 clk = ~clk;

    endian_lane_steer dut (.*);

    function automatic bit misal(logic [1:0] sz, logic [1:0] a);
        return sz == 2'd3 || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a != 2'd0);
    endfunction

    function automatic int nbytes(logic [1:0] sz);
        return 1 << sz;
    endfunction

    // Lane holding value byte k, per R1..R4.
    function automatic logic [1:0] lane_of(logic [1:0] md, logic [1:0] sz,
                                           logic [1:0] a, int k);
        int n = nbytes(sz);
        case (md)
            2'd1: return 2'(a + (n - 1 - k));
            2'd2: return (sz == 2'd0) ? 2'((a ^ 2'd3) + k)
                       : (sz == 2'd1) ? 2'((a ^ 2'd2) + k) : 2'(a + k);
            2'd3: return (sz == 2'd2) ? 2'(k ^ 2) : 2'(a + k);
            default: return 2'(a + k);
        endcase
    endfunction

    function automatic logic [31:0] extend(logic [31:0] v, logic [1:0] sz, bit sg);
        if (sz == 2'd0) return sg ? {{24{v[7]}}, v[7:0]} : {24'd0, v[7:0]};
        if (sz == 2'd1) return sg ? {{16{v[15]}}, v[15:0]} : {16'd0, v[15:0]};
        return v;
    endfunction

    function automatic logic [31:0] ref_load(logic [1:0] md, logic [1:0] sz,
                                             logic [1:0] a, bit sg, logic [31:0] w);
        logic [31:0] v = '0;
        if (misal(sz, a)) return '0;
        for (int k = 0; k < nbytes(sz); k++) v[k*8 +: 8] = w[lane_of(md, sz, a, k)*8 +: 8];
        return extend(v, sz, sg);
    endfunction

    function automatic logic [31:0] mem_word();
        return {mem[3], mem[2], mem[1], mem[0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Store: called just after a falling edge, returns at the next one.
    task automatic do_store(logic [1:0] md, logic [1:0] sz, logic [31:0] ad,
                            logic [31:0] d, string req);
        logic [3:0]  ebe = '0;
        logic [31:0] ewd = '0;
        acc_addr = ad; acc_size = sz; order_mode = md; acc_write = 1'b1;
        st_data = d; bus_rvalid = 1'b0;
        if (!misal(sz, ad[1:0]))
            for (int k = 0; k < nbytes(sz); k++) begin
                ebe[lane_of(md, sz, ad[1:0], k)] = 1'b1;
                ewd[lane_of(md, sz, ad[1:0], k)*8 +: 8] = d[k*8 +: 8];
            end
        #1;
        chk({req, " enables"}, {28'd0, bus_be}, {28'd0, ebe});
        chk({req, " wdata"}, bus_wdata, ewd);
        chk({req, " R5 err"}, {31'd0, align_err}, {31'd0, misal(sz, ad[1:0])});
        for (int l = 0; l < 4; l++) if (bus_be[l]) mem[l] = bus_wdata[l*8 +: 8];
        @(negedge clk);
        acc_write = 1'b0;
    endtask

    task automatic do_load(logic [1:0] md, logic [1:0] sz, logic [31:0] ad, bit sg,
                           string req);
        acc_addr = ad; acc_size = sz; order_mode = md; acc_write = 1'b0;
        acc_signed = sg; bus_rdata = mem_word(); bus_rvalid = 1'b1;
        @(negedge clk);
        bus_rvalid = 1'b0;
        #1;
        chk({req, " load"}, ld_data, ref_load(md, sz, ad[1:0], sg, mem_word()));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        for (int i = 0; i < 4; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R7 reset", ld_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: half-swapped word layout
        do_store(2'd3, 2'd2, 32'h100, 32'h4A4F484E, "R4 mixed word");
        chk("R4 lane image", mem_word(), 32'h484E4A4F);
        do_load(2'd3, 2'd2, 32'h100, 1'b0, "R4 mixed word");
        chk("R8 mixed round trip", ld_data, 32'h4A4F484E);

        // R9: one small value, three widths
        do_store(2'd0, 2'd2, 32'h200, 32'h0000004A, "R9 store");
        do_load(2'd0, 2'd0, 32'h200, 1'b0, "R9 byte");
        chk("R9 byte value", ld_data, 32'h4A);
        do_load(2'd0, 2'd1, 32'h200, 1'b0, "R9 half");
        chk("R9 half value", ld_data, 32'h4A);
        do_load(2'd0, 2'd2, 32'h200, 1'b0, "R9 word");
        chk("R9 word value", ld_data, 32'h4A);

        // R6: sign extension
        do_store(2'd0, 2'd0, 32'h3, 32'h80, "R1 byte lane3");
        do_load(2'd0, 2'd0, 32'h3, 1'b1, "R6 signed byte");
        chk("R6 sign value", ld_data, 32'hFFFFFF80);
        do_load(2'd0, 2'd0, 32'h3, 1'b0, "R6 unsigned byte");
        chk("R6 zero value", ld_data, 32'h80);

        // R3: mirrored byte lane; R2: reversed halfword
        do_store(2'd2, 2'd0, 32'h0, 32'hA5, "R3 byte");
        chk("R3 lane3 holds byte", {24'd0, mem[3]}, 32'hA5);
        do_store(2'd1, 2'd1, 32'h2, 32'h1234, "R2 half");
        chk("R2 lane2", {24'd0, mem[2]}, 32'h12);

        // R7: hold while no read is valid
        bus_rdata = 32'hDEADBEEF;
        do_load(2'd0, 2'd2, 32'h0, 1'b0, "R7 prime");
        bus_rdata = 32'h0BADF00D;
        @(negedge clk); #1;
        chk("R7 hold", ld_data, ref_load(2'd0, 2'd2, 2'd0, 1'b0, mem_word()));

        // R5: misaligned refusal clears the result
        do_store(2'd0, 2'd1, 32'h1, 32'hFFFF, "R5 odd half");
        do_load(2'd2, 2'd2, 32'h2, 1'b0, "R5 word off");
        chk("R5 zero result", ld_data, 32'd0);

        for (int it = 0; it < 400; it++) begin
            logic [1:0]  md = 2'($urandom_range(0, 3));
            logic [1:0]  sz = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            logic [31:0] ad = $urandom;
            logic [31:0] d  = $urandom;
            bit          sg = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 5) != 0) begin
                if (sz == 2'd1) ad[0] = 1'b0;
                if (sz == 2'd2) ad[1:0] = 2'b00;
            end
            do_store(md, sz, ad, d, "R1 R2 R3 R4 store");
            do_load(md, sz, ad, sg, "R6 load");
            if (!misal(sz, ad[1:0]))
                chk("R8 round trip", ld_data, extend(d, sz, sg));
            do_load(2'($urandom_range(0, 3)), 2'($urandom_range(0, 2)),
                    $urandom, 1'($urandom_range(0, 1)), "R6 cross load");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule